// File: doc/BRIEF.md
# Instruction Decode and Length Unit

This unit sits between the fetch stage and the execution sequencer of a small 16-bit word-addressed processor. It splits the leading word of an instruction into an operation code and two operand selectors. From the selector codes it works out whether zero, one or two extension words follow the leading word, and it routes the fetched extension words to the operand that owns them. It also expands the short literal selectors of the source operand, and it flags instructions of the conditional-test class. The skip logic of the sequencer needs that flag so that it can keep skipping through a chain of conditionals.

The decode itself is combinational. Its result goes through a one-entry registered output stage with a valid/ready handshake, so a multi-cycle sequencer can hold the result for as long as it needs. The fetch side supplies the leading word together with the two words stored after it. The unit decides which of those two words it uses.

Top module: `idec_len_unit`

## Requirements
- R1: The operation code is taken from bits 4:0 of the leading word. The destination selector (b) is taken from bits 9:5 and the source selector (a) from bits 15:10.
- R2: With a nonzero operation code, b claims an extension word exactly when its selector is in 0x10..0x17, or equals 0x1e or 0x1f. Selectors 0x18 and 0x0f claim none.
- R3: With an operation code of zero, b is a secondary code. It never claims an extension word, and the secondary flag is 1.
- R4: a claims an extension word for the selector values listed in R2. It does so only when the operation code is nonzero, or when the code is zero and the b selector is nonzero. With code and b both zero, a claims none.
- R5: The length output (2 bits) equals 1 plus the number of claimed extension words. Possible values are 1, 2 and 3.
- R6: b's word is the first word after the leading word. a's word is the first word when b claims none, and the second word otherwise. An operand that claims no word presents 0x0000.
- R7: An a selector of 0x20..0x3f sets the literal flag. The literal value is (selector & 0x1f) − 1 modulo 2^16, so 0x20 gives 0xffff, 0x21 gives 0x0000 and 0x3f gives 0x001e. For other selectors the flag is 0 and the value is 0x0000.
- R8: The conditional flag is 1 exactly for operation codes 0x10..0x17.
- R9: A word is accepted on a rising edge where in_valid and in_ready are both 1, and its decode is presented with out_valid one cycle later. in_ready is 1 whenever the output stage is empty or is being drained.
- R10: While out_valid is 1 and out_ready is 0, all outputs hold their values and no new word is accepted.
- R11: After a synchronous active-low reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Leading word and following words are valid |
| in_ready | output | 1 | Unit can accept a word this cycle |
| in_word | input | 16 | Leading instruction word |
| in_ext0 | input | 16 | First word after the leading word |
| in_ext1 | input | 16 | Second word after the leading word |
| out_valid | output | 1 | Decoded result is valid |
| out_ready | input | 1 | Consumer takes the result |
| out_opc | output | 5 | Operation code |
| out_sel_b | output | 5 | Destination selector or secondary code |
| out_sel_a | output | 6 | Source selector |
| out_secondary | output | 1 | Operation code is zero |
| out_b_ext | output | 1 | b claims an extension word |
| out_a_ext | output | 1 | a claims an extension word |
| out_len | output | 2 | Instruction length in words |
| out_b_word | output | 16 | Extension word routed to b |
| out_a_word | output | 16 | Extension word routed to a |
| out_lit_vld | output | 1 | a is a short literal |
| out_lit | output | 16 | Expanded short literal |
| out_cond | output | 1 | Conditional-test class |

## Verification
A wrong claim decision shows up at once as a wrong length. It also moves a's word onto the wrong fetched word in the same output cycle, so the bench compares the routed words as well as the flags. A fault in the output register shows up as a lost or duplicated result during a stall. The stall scenario holds the stage for several cycles with a second word waiting, and then checks that the held result and the next result appear in order. An off-by-one fault in the literal expansion appears only at the ends of the range, so selectors 0x20, 0x21 and 0x3f are each checked on the cycle after acceptance.

// File: rtl/idec_pkg.sv
// Shared widths, selector code points and the decoded-instruction record.
// Assumes the leading word is exactly opcode + b selector + a selector wide.
package idec_pkg;
    parameter int WORD_W = 16;
    parameter int OPC_W  = 5;
    parameter int SELB_W = 5;
    parameter int SELA_W = 6;
    parameter int LEN_W  = 2;

    localparam int B_LSB = OPC_W;
    localparam int A_LSB = OPC_W + SELB_W;

    localparam logic [SELA_W-1:0] SEL_IDX_LO = SELA_W'(8'h10);
    localparam logic [SELA_W-1:0] SEL_IDX_HI = SELA_W'(8'h17);
    localparam logic [SELA_W-1:0] SEL_NW_IND = SELA_W'(8'h1e);
    localparam logic [SELA_W-1:0] SEL_NW_LIT = SELA_W'(8'h1f);
    localparam logic [OPC_W-1:0]  COND_LO    = OPC_W'(8'h10);
    localparam logic [OPC_W-1:0]  COND_HI    = OPC_W'(8'h17);

    typedef struct packed {
        logic [OPC_W-1:0]  opc;
        logic [SELB_W-1:0] sel_b;
        logic [SELA_W-1:0] sel_a;
        logic              secondary;
        logic              b_ext;
        logic              a_ext;
        logic [LEN_W-1:0]  len;
        logic [WORD_W-1:0] b_word;
        logic [WORD_W-1:0] a_word;
        logic              lit_vld;
        logic [WORD_W-1:0] lit;
        logic              cond;
    } idec_t;

    // True when a selector code consumes one extension word.
    function automatic logic sel_needs_ext(input logic [SELA_W-1:0] s);
        return ((s >= SEL_IDX_LO) && (s <= SEL_IDX_HI)) ||
               (s == SEL_NW_IND) || (s == SEL_NW_LIT);
    endfunction
endpackage

// File: rtl/idec_split.sv
// Splits the leading word into opcode, b selector and a selector.
// Assumes WORD_W == OPC_W + SELB_W + SELA_W (checked at elaboration).
module idec_split
    import idec_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic [OPC_W-1:0]  opc,
    output logic [SELB_W-1:0] sel_b,
    output logic [SELA_W-1:0] sel_a
);
    if (WORD_W != OPC_W + SELB_W + SELA_W) begin : g_bad_widths
        $error("idec_split: field widths do not fill the word");
    end

    // Field extraction.
    always_comb begin
        opc   = word[OPC_W-1:0];
        sel_b = word[B_LSB +: SELB_W];
        sel_a = word[A_LSB +: SELA_W];
    end
endmodule

// File: rtl/idec_operand.sv
// Classifies one operand selector: extension-word claim and, for the
// source variant, short-literal expansion. Assumes SEL_W <= SELA_W.
module idec_operand
    import idec_pkg::*;
#(
    parameter int SEL_W   = SELB_W,
    parameter bit HAS_LIT = 1'b0
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic              ext_allowed,
    output logic              needs_ext,
    output logic              lit_vld,
    output logic [WORD_W-1:0] lit
);
    localparam int LIT_W = SELA_W - 1;

    logic [SELA_W-1:0] wide;

    // Widen the selector and decide the extension-word claim.
    always_comb begin
        wide      = SELA_W'(sel);
        needs_ext = ext_allowed && sel_needs_ext(wide);
    end

    if (HAS_LIT) begin : g_lit
        // Top selector bit marks a literal; value carries an offset of -1.
        always_comb begin
            lit_vld = wide[SELA_W-1];
            lit     = lit_vld ? (WORD_W'(wide[LIT_W-1:0]) - WORD_W'(1)) : '0;
        end
    end else begin : g_no_lit
        // Destination operands never carry a literal.
        always_comb begin
            lit_vld = 1'b0;
            lit     = '0;
        end
    end
endmodule

// File: rtl/idec_pipe.sv
// One-entry registered output stage with valid/ready handshake.
// Assumes the consumer may hold out_ready low for any number of cycles.
module idec_pipe
    import idec_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  in_valid,
    output logic  in_ready,
    input  idec_t d,
    output logic  out_valid,
    input  logic  out_ready,
    output idec_t q
);
    // Space exists when empty or when the held entry leaves this cycle.
    always_comb in_ready = !out_valid || out_ready;

    // Load a new entry on accept, drop the old one when drained.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            q         <= '0;
        end else if (in_valid && in_ready) begin
            out_valid <= 1'b1;
            q         <= d;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/idec_len_unit.sv
// Instruction decode and length unit: field split, extension-word claims,
// word routing, literal expansion and conditional-class flag, followed by
// a registered handshake stage. Assumes in_ext0/in_ext1 are the two words
// stored after in_word, valid together with it.
module idec_len_unit
    import idec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    input  logic [WORD_W-1:0] in_ext0,
    input  logic [WORD_W-1:0] in_ext1,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [OPC_W-1:0]  out_opc,
    output logic [SELB_W-1:0] out_sel_b,
    output logic [SELA_W-1:0] out_sel_a,
    output logic              out_secondary,
    output logic              out_b_ext,
    output logic              out_a_ext,
    output logic [LEN_W-1:0]  out_len,
    output logic [WORD_W-1:0] out_b_word,
    output logic [WORD_W-1:0] out_a_word,
    output logic              out_lit_vld,
    output logic [WORD_W-1:0] out_lit,
    output logic              out_cond
);
    logic [OPC_W-1:0]  opc;
    logic [SELB_W-1:0] sel_b;
    logic [SELA_W-1:0] sel_a;
    logic              secondary;
    logic              a_allowed;
    logic              b_ext, a_ext;
    logic              b_lit_vld, a_lit_vld;
    logic [WORD_W-1:0] b_lit, a_lit;
    idec_t             dec, held;

    idec_split u_split (
        .word  (in_word),
        .opc   (opc),
        .sel_b (sel_b),
        .sel_a (sel_a)
    );

    // Claim permissions: b only for primary ops, a unless code and b are both zero.
    always_comb begin
        secondary = (opc == '0);
        a_allowed = !secondary || (sel_b != '0);
    end

    idec_operand #(.SEL_W(SELB_W), .HAS_LIT(1'b0)) u_opb (
        .sel         (sel_b),
        .ext_allowed (!secondary),
        .needs_ext   (b_ext),
        .lit_vld     (b_lit_vld),
        .lit         (b_lit)
    );

    idec_operand #(.SEL_W(SELA_W), .HAS_LIT(1'b1)) u_opa (
        .sel         (sel_a),
        .ext_allowed (a_allowed),
        .needs_ext   (a_ext),
        .lit_vld     (a_lit_vld),
        .lit         (a_lit)
    );

    // Assemble the decoded record, routing extension words in claim order.
    always_comb begin
        dec.opc       = opc;
        dec.sel_b     = sel_b;
        dec.sel_a     = sel_a;
        dec.secondary = secondary;
        dec.b_ext     = b_ext;
        dec.a_ext     = a_ext;
        dec.len       = LEN_W'(1) + LEN_W'(b_ext) + LEN_W'(a_ext);
        dec.b_word    = b_ext ? in_ext0 : '0;
        dec.a_word    = a_ext ? (b_ext ? in_ext1 : in_ext0) : '0;
        dec.lit_vld   = a_lit_vld | b_lit_vld;
        dec.lit       = a_lit | b_lit;
        dec.cond      = (opc >= COND_LO) && (opc <= COND_HI);
    end

    idec_pipe u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .d         (dec),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .q         (held)
    );

    // Drive the output ports from the held record.
    always_comb begin
        out_opc       = held.opc;
        out_sel_b     = held.sel_b;
        out_sel_a     = held.sel_a;
        out_secondary = held.secondary;
        out_b_ext     = held.b_ext;
        out_a_ext     = held.a_ext;
        out_len       = held.len;
        out_b_word    = held.b_word;
        out_a_word    = held.a_word;
        out_lit_vld   = held.lit_vld;
        out_lit       = held.lit;
        out_cond      = held.cond;
    end
endmodule

// File: rtl/idec_len_unit_chk.sv
// Port-level protocol and consistency checks for idec_len_unit.
module idec_len_unit_chk
    import idec_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [OPC_W-1:0]  out_opc,
    input logic [SELA_W-1:0] out_sel_a,
    input logic              out_secondary,
    input logic              out_b_ext,
    input logic              out_a_ext,
    input logic [LEN_W-1:0]  out_len,
    input logic [WORD_W-1:0] out_a_word,
    input logic              out_lit_vld,
    input logic              out_cond
);
    // R11
    rst_empty_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

    // R9
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_opc) &&
            $stable(out_len) && $stable(out_a_word) && $stable(out_sel_a)));

    // R3
    secondary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_opc == '0) |-> (out_secondary && !out_b_ext));

    // R5
    len_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_len == LEN_W'(1) + LEN_W'(out_b_ext) + LEN_W'(out_a_ext)));

    // R7
    literal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_lit_vld) |-> (out_sel_a[SELA_W-1] && !out_a_ext));

    // R8
    cond_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_cond) |-> (out_opc >= COND_LO && out_opc <= COND_HI));
endmodule

bind idec_len_unit idec_len_unit_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_opc       (out_opc),
    .out_sel_a     (out_sel_a),
    .out_secondary (out_secondary),
    .out_b_ext     (out_b_ext),
    .out_a_ext     (out_a_ext),
    .out_len       (out_len),
    .out_a_word    (out_a_word),
    .out_lit_vld   (out_lit_vld),
    .out_cond      (out_cond)
);

// File: tb/sim_idec_len_unit.sv
module sim_idec_len_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_word = '0, in_ext0 = '0, in_ext1 = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [4:0]  out_opc;
    logic [4:0]  out_sel_b;
    logic [5:0]  out_sel_a;
    logic        out_secondary, out_b_ext, out_a_ext;
    logic [1:0]  out_len;
    logic [15:0] out_b_word, out_a_word;
    logic        out_lit_vld;
    logic [15:0] out_lit;
    logic        out_cond;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    idec_len_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .in_ext0(in_ext0), .in_ext1(in_ext1),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_opc(out_opc), .out_sel_b(out_sel_b), .out_sel_a(out_sel_a),
        .out_secondary(out_secondary), .out_b_ext(out_b_ext), .out_a_ext(out_a_ext),
        .out_len(out_len), .out_b_word(out_b_word), .out_a_word(out_a_word),
        .out_lit_vld(out_lit_vld), .out_lit(out_lit), .out_cond(out_cond)
    );

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic bit claims(input logic [5:0] s);
        return (s >= 6'h10 && s <= 6'h17) || s == 6'h1e || s == 6'h1f;
    endfunction

    // Present one instruction, take it, and check every decoded output.
    task automatic run_one(input logic [4:0] op, input logic [4:0] b, input logic [5:0] a,
                           input logic [15:0] e0, input logic [15:0] e1);
        bit eb, ea;
        logic [15:0] xb, xa, xl;
        eb = (op != 0) && claims({1'b0, b});
        ea = ((op != 0) || (b != 0)) && claims(a);
        xb = eb ? e0 : 16'h0;
        xa = ea ? (eb ? e1 : e0) : 16'h0;
        xl = a[5] ? ({11'h0, a[4:0]} - 16'h1) : 16'h0;
        @(negedge clk);
        in_word = {a, b, op}; in_ext0 = e0; in_ext1 = e1; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R9", "out_valid", 16'(out_valid), 16'h1);
        check("R1", "opc", 16'(out_opc), 16'(op));
        check("R1", "sel_b", 16'(out_sel_b), 16'(b));
        check("R1", "sel_a", 16'(out_sel_a), 16'(a));
        check("R2", "b_ext", 16'(out_b_ext), 16'(eb));
        check("R3", "secondary", 16'(out_secondary), 16'(op == 0));
        check("R4", "a_ext", 16'(out_a_ext), 16'(ea));
        check("R5", "len", 16'(out_len), 16'(1 + int'(eb) + int'(ea)));
        check("R6", "b_word", out_b_word, xb);
        check("R6", "a_word", out_a_word, xa);
        check("R7", "lit_vld", 16'(out_lit_vld), 16'(a[5]));
        check("R7", "lit", out_lit, xl);
        check("R8", "cond", 16'(out_cond), 16'(op >= 5'h10 && op <= 5'h17));
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R11", "out_valid after reset", 16'(out_valid), 16'h0);
        check("R11", "in_ready after reset", 16'(in_ready), 16'h1);
        rst_n = 1'b1;
    endtask

    task automatic test_lengths();
        run_one(5'h01, 5'h00, 6'h21, 16'h1111, 16'h2222); // R5 length 1
        run_one(5'h02, 5'h10, 6'h1f, 16'hAAAA, 16'hBBBB); // R6 both words
        run_one(5'h03, 5'h01, 6'h1e, 16'hCCCC, 16'hDDDD); // R6 a takes first word
        run_one(5'h04, 5'h17, 6'h08, 16'h1234, 16'h5678); // R2 upper index
        run_one(5'h05, 5'h18, 6'h17, 16'h0F0F, 16'hF0F0); // R2 0x18 no claim
        run_one(5'h06, 5'h0f, 6'h10, 16'h7777, 16'h8888); // R2 0x0f no claim
    endtask

    task automatic test_secondary();
        run_one(5'h00, 5'h01, 6'h10, 16'h4444, 16'h5555); // R3 R4
        run_one(5'h00, 5'h1f, 6'h1e, 16'h6666, 16'h9999); // R3 b code looks like claim
        run_one(5'h00, 5'h00, 6'h1f, 16'hABCD, 16'hEF01); // R4 both zero
    endtask

    task automatic test_literals();
        run_one(5'h01, 5'h02, 6'h20, 16'h0, 16'h0); // R7 0xffff
        run_one(5'h01, 5'h02, 6'h21, 16'h0, 16'h0); // R7 0x0000
        run_one(5'h01, 5'h02, 6'h3f, 16'h0, 16'h0); // R7 0x001e
        run_one(5'h01, 5'h02, 6'h1f, 16'h3333, 16'h0); // R7 not literal
    endtask

    task automatic test_cond();
        run_one(5'h10, 5'h00, 6'h00, 16'h0, 16'h0); // R8
        run_one(5'h17, 5'h00, 6'h00, 16'h0, 16'h0); // R8
        run_one(5'h0f, 5'h00, 6'h00, 16'h0, 16'h0); // R8
        run_one(5'h18, 5'h00, 6'h00, 16'h0, 16'h0); // R8
    endtask

    // Hold the output stage with a second word waiting, then release.
    task automatic test_stall();
        @(negedge clk);
        out_ready = 1'b0;
        in_word = {6'h1f, 5'h10, 5'h02}; in_ext0 = 16'h0A0A; in_ext1 = 16'h0B0B;
        in_valid = 1'b1;
        @(negedge clk);
        in_word = {6'h21, 5'h03, 5'h01}; in_ext0 = 16'h0C0C; in_ext1 = 16'h0D0D;
        check("R10", "in_ready during stall", 16'(in_ready), 16'h0);
        repeat (3) @(negedge clk);
        check("R10", "out_valid held", 16'(out_valid), 16'h1);
        check("R10", "len held", 16'(out_len), 16'h3);
        check("R10", "a_word held", out_a_word, 16'h0B0B);
        check("R10", "opc held", 16'(out_opc), 16'h02);
        out_ready = 1'b1;
        #1;
        check("R9", "in_ready while draining", 16'(in_ready), 16'h1);
        @(negedge clk);
        in_valid = 1'b0;
        check("R9", "second word opc", 16'(out_opc), 16'h01);
        check("R9", "second word len", 16'(out_len), 16'h1);
        check("R9", "second word lit", out_lit, 16'h0000);
        @(negedge clk);
        check("R9", "drained", 16'(out_valid), 16'h0);
    endtask

    initial begin
        test_reset();
        test_lengths();
        test_secondary();
        test_literals();
        test_cond();
        test_stall();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule